// File: doc/BRIEF.md
# Multi-Rate Sample Word Interleaver

This block builds 16-bit storage words from channel samples taken on a fast tick. A rate selector trades channel count for samples per word. At the single rate, each tick fills a whole word with 16 channels. At the double rate, two successive ticks of 8 channels share one word. At the quadruple rate, four successive ticks of 4 channels share one word.

The bits of successive samples are interleaved, not packed as contiguous fields. Word bit `c * S + k` carries channel `c` of sample `k`, where `S` is the number of samples per word and sample 0 is the earliest. One finished word leaves the block per completed group, marked by a one-cycle valid pulse.

The rate selector is applied per tick. If it changes while a word is partly gathered, the partial samples are dropped. The tick that sees the new rate then becomes sample 0 of a fresh word.

Top module: `sample_word_interleaver`

## Requirements
- R1: During and after reset, `word_valid_o` is 0 and `word_o` is all zeros until the first word completes.
- R2: With `rate_sel_i` = 2'b00 (single rate), every tick completes a word. In the next cycle, `word_o` equals `chan_i` as sampled at that tick.
- R3: With `rate_sel_i` = 2'b01 (double rate), two ticks complete a word. Word bit `2*c + k` equals bit `c` (c in 0..7) of the k-th tick's `chan_i`.
- R4: With `rate_sel_i` = 2'b10 (quadruple rate), four ticks complete a word. Word bit `4*c + k` equals bit `c` (c in 0..3) of the k-th tick's `chan_i`.
- R5: At the double and quadruple rates, `chan_i` bits at positions 8 and above (double) or 4 and above (quadruple) have no effect on `word_o`.
- R6: `word_valid_o` is high for exactly one cycle, the cycle after the tick that completes a word. It is low in every other cycle.
- R7: Cycles without `tick_i` change neither the gathered samples nor the position within the word. Ticks may be spaced by any number of idle cycles.
- R8: When a tick arrives with a rate different from the rate in use, any partly gathered samples are dropped. That tick becomes sample 0 of a new word at the new rate.
- R9: `rate_sel_i` = 2'b11 behaves exactly like the single rate.
- R10: `word_o` holds the last completed word in every cycle in which `word_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel_i | input | 2 | Rate selector: 00 single, 01 double, 10 quadruple, 11 single |
| tick_i | input | 1 | Sample strobe; `chan_i` is taken when high |
| chan_i | input | WORD_W | Channel levels for this tick |
| word_o | output | WORD_W | Last completed interleaved word |
| word_valid_o | output | 1 | One-cycle pulse when `word_o` has been updated |

## Verification
The bench targets rate switches in the middle of a word. A design that kept stale samples would emit a word early, or with bits from the old rate mixed in. Widely spaced ticks at the quadruple rate catch a position counter that advances on idle cycles; such a design shuffles the sample order. Random high channel bits at the reduced rates expose a scatter network that indexes the wrong channel. The reserved selector code is run against the single-rate result to catch a decoder that maps it to a multi-sample rate.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int RATE_LOG_MAX = 2;
  localparam int IDX_W = 2;
  localparam int LOG_W = 2;

  typedef enum logic [1:0] {
    RATE_X1   = 2'b00,
    RATE_X2   = 2'b01,
    RATE_X4   = 2'b10,
    RATE_RSVD = 2'b11
  } rate_e;

  // log2 of samples per word for a selector value
  function automatic logic [LOG_W-1:0] rate_log(input logic [1:0] sel);
    case (sel)
      RATE_X2: return LOG_W'(1);
      RATE_X4: return LOG_W'(2);
      default: return LOG_W'(0);
    endcase
  endfunction

  // index of the sample that closes a word
  function automatic logic [IDX_W-1:0] final_index(input logic [LOG_W-1:0] lg);
    return IDX_W'((32'd1 << lg) - 32'd1);
  endfunction
endpackage

// File: rtl/swi_gather.sv
module swi_gather
  import swi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [LOG_W-1:0] req_log_i,
  output logic [LOG_W-1:0] eff_log_o,
  output logic [IDX_W-1:0] eff_idx_o,
  output logic             first_o,
  output logic             last_o,
  output logic             drop_o
);
  logic [LOG_W-1:0] act_log_q;
  logic [IDX_W-1:0] idx_q;
  logic             rate_switch;

  assign rate_switch = tick_i && (req_log_i != act_log_q);
  assign eff_log_o   = rate_switch ? req_log_i : act_log_q;
  assign eff_idx_o   = rate_switch ? '0 : idx_q;
  assign first_o     = (eff_idx_o == '0);
  assign last_o      = tick_i && (eff_idx_o == final_index(eff_log_o));
  assign drop_o      = rate_switch && (idx_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_log_q <= '0;
      idx_q     <= '0;
    end else if (tick_i) begin
      act_log_q <= req_log_i;
      idx_q     <= last_o ? '0 : eff_idx_o + IDX_W'(1);
    end
  end

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= final_index(act_log_q));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(idx_q) && $stable(act_log_q)));

  assert_drop_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_o && req_log_i != '0) |=> (idx_q == IDX_W'(1)));
endmodule

// File: rtl/swi_scatter.sv
module swi_scatter
  import swi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] sample_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [LOG_W-1:0]  log_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] merged_o
);
  logic [WORD_W-1:0] cand [RATE_LOG_MAX+1];

  for (genvar l = 0; l <= RATE_LOG_MAX; l++) begin : g_rate
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam int CH = b >> l;
      localparam int K  = b % (1 << l);
      assign cand[l][b] = (idx_i == IDX_W'(K)) ? sample_i[CH] : base_i[b];
    end
  end

  always_comb begin
    merged_o = cand[0];
    for (int l = 1; l <= RATE_LOG_MAX; l++)
      if (log_i == LOG_W'(l)) merged_o = cand[l];
  end
endmodule

// File: rtl/sample_word_interleaver.sv
module sample_word_interleaver
  import swi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel_i,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] chan_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  logic [LOG_W-1:0]  eff_log;
  logic [IDX_W-1:0]  eff_idx;
  logic              word_first, word_last, word_drop;
  logic [WORD_W-1:0] acc_q, base, merged;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  swi_gather u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .req_log_i (rate_log(rate_sel_i)),
    .eff_log_o (eff_log),
    .eff_idx_o (eff_idx),
    .first_o   (word_first),
    .last_o    (word_last),
    .drop_o    (word_drop)
  );

  assign base = word_first ? '0 : acc_q;

  swi_scatter #(.WORD_W(WORD_W)) u_scatter (
    .sample_i (chan_i),
    .base_i   (base),
    .log_i    (eff_log),
    .idx_i    (eff_idx),
    .merged_o (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= word_last;
      if (tick_i) acc_q <= merged;
      if (word_last) word_q <= merged;
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = valid_q;

  assert_valid_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(tick_i));

  assert_single_every_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && rate_log(rate_sel_i) == '0) |=> word_valid_o);

  assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));

  assert_drop_no_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_drop && rate_log(rate_sel_i) != '0) |=> !word_valid_o);
endmodule

// File: tb/sim_sample_word_interleaver.sv
`timescale 1ns/1ps
module sim_sample_word_interleaver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_sel = 2'b00;
  logic        tick = 1'b0;
  logic [15:0] chan = '0;
  logic [15:0] word;
  logic        word_valid;

  int checks = 0;
  int fails = 0;

  sample_word_interleaver #(.WORD_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel), .tick_i(tick),
    .chan_i(chan), .word_o(word), .word_valid_o(word_valid)
  );

  always #5 clk = ~clk;

  // reference model state
  int          m_spw = 1;
  int          m_cnt = 0;
  logic [15:0] m_samp [4];
  logic [15:0] m_last_word = '0;
  logic        m_exp_valid = 1'b0;
  string       word_tag = "R2";

  function automatic int spw_of(input logic [1:0] sel);
    if (sel == 2'b01) return 2;
    if (sel == 2'b10) return 4;
    return 1;
  endfunction

  function automatic logic [15:0] build(input int spw, input logic [15:0] s0,
      input logic [15:0] s1, input logic [15:0] s2, input logic [15:0] s3);
    logic [15:0] w = '0;
    logic [15:0] s [4];
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    for (int b = 0; b < 16; b++) w[b] = s[b % spw][b / spw];
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, then check at the next falling edge
  task automatic step(input logic t, input logic [1:0] sel, input logic [15:0] c);
    int s;
    rate_sel = sel; tick = t; chan = c;
    m_exp_valid = 1'b0;
    if (t) begin
      s = spw_of(sel);
      if (s != m_spw) begin m_spw = s; m_cnt = 0; end
      m_samp[m_cnt] = c;
      if (m_cnt == m_spw - 1) begin
        m_last_word = build(m_spw, m_samp[0], m_samp[1], m_samp[2], m_samp[3]);
        m_exp_valid = 1'b1;
        m_cnt = 0;
      end else m_cnt++;
    end
    @(negedge clk);
    check("R6", {15'd0, word_valid}, {15'd0, m_exp_valid});
    check(m_exp_valid ? word_tag : "R10", word, m_last_word);
  endtask

  function automatic string tag_of(input logic [1:0] sel);
    case (sel)
      2'b01: return "R3";
      2'b10: return "R4";
      2'b11: return "R9";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1", {15'd0, word_valid}, 16'd0);
    check("R1", word, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", word, 16'd0);

    // R2 single rate
    word_tag = "R2";
    step(1, 2'b00, 16'hA5C3);
    step(1, 2'b00, 16'h0001);
    step(0, 2'b00, 16'hFFFF);
    // R3 double rate: ch0..7 of sample0 = FF, sample1 = 00 -> 0x5555
    word_tag = "R3";
    step(1, 2'b01, 16'h00FF);
    step(1, 2'b01, 16'h0000);
    check("R3", word, 16'h5555);
    // R5 upper bits ignored at double and quadruple
    word_tag = "R5";
    step(1, 2'b01, 16'hFF00);
    step(1, 2'b01, 16'hFF00);
    check("R5", word, 16'h0000);
    step(1, 2'b10, 16'hFFF0);
    step(1, 2'b10, 16'hFFF0);
    step(1, 2'b10, 16'hFFF0);
    step(1, 2'b10, 16'hFFF1);
    check("R5", word, 16'h0008);
    // R7 quadruple with idle gaps: samples 1,2,4,8 on ch0..3
    word_tag = "R7";
    step(1, 2'b10, 16'h0001);
    repeat (5) step(0, 2'b10, 16'hFFFF);
    step(1, 2'b10, 16'h0002);
    step(0, 2'b01, 16'h1234);
    step(1, 2'b10, 16'h0004);
    repeat (3) step(0, 2'b00, 16'h0F0F);
    step(1, 2'b10, 16'h0008);
    check("R4", word, 16'h8421);
    // R8 switch mid word: quad partial then double
    word_tag = "R8";
    step(1, 2'b10, 16'h000F);
    step(1, 2'b10, 16'h000F);
    step(1, 2'b01, 16'h0000);
    step(1, 2'b01, 16'h00FF);
    check("R8", word, 16'hAAAA);
    step(1, 2'b01, 16'h00AA);
    step(1, 2'b00, 16'h1357);
    check("R8", word, 16'h1357);
    // R9 reserved code
    word_tag = "R9";
    step(1, 2'b11, 16'hBEEF);
    check("R9", word, 16'hBEEF);

    // random phase
    for (int seg = 0; seg < 200; seg++) begin
      logic [1:0] sel = 2'($urandom_range(0, 3));
      int len = $urandom_range(1, 12);
      for (int i = 0; i < len; i++) begin
        word_tag = (m_spw != spw_of(sel)) ? "R8" : tag_of(sel);
        step(1'($urandom_range(0, 2) != 0), sel, 16'($urandom()));
        if (m_cnt != 0 || m_exp_valid) word_tag = tag_of(sel);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule